// File: doc/BRIEF.md
# Two-Part Interframe Deferral Timer

This block decides when a half-duplex 10 Mb/s Ethernet MAC may begin a transmission. It counts the gap that must separate frames on the medium in bit times, using a one-cycle pulse that the surrounding MAC raises once per bit time. The gap has two parts. Carrier seen during the first part pushes the count back to zero. Carrier seen during the second part is ignored, so that a station with a frame waiting gets fair access to the medium.

After the block's own frame, counting waits until both the transmit engine and carrier sense have gone idle. A blinding window then covers the early part of the gap, so that the transceiver's self-test burst cannot reset the timer. A configuration input turns off the two-part rule after transmissions only, and in that case the whole post-transmit gap runs straight through. The gap after a received frame keeps the two-part rule in every configuration.

The transmit engine watches `tx_permit`. It starts a frame only while that output is high, and it raises `tx_busy` for the length of the frame.

Top module: `ifg_defer_timer`

## Requirements
- R1: After reset `tx_permit` is low and the gap count is zero. With carrier low and a request pending, the first permit needs 96 bit ticks.
- R2: After receive carrier drops, `tx_permit` (with `tx_request` high) rises in the cycle after the 96th bit tick and is low after the 95th.
- R3: After a received frame, carrier seen while fewer than 60 ticks have been counted holds the count at zero. Once carrier drops, a full 96 ticks are needed again.
- R4: Once 60 or more ticks are counted, carrier does not reset the count. With a request pending, the permit rises at 96 ticks even while carrier is high.
- R5: `tx_permit` is high only while `tx_request` is high. If the gap is complete, no request is pending and carrier appears, the block defers to it, and a new full gap is needed after carrier drops.
- R6: After the block's own frame, no ticks are counted while `tx_busy` or `carrier_sense` is high. Counting starts from zero once both are low.
- R7: After the block's own frame (with `post_tx_plain_gap` low), carrier seen while fewer than 40 ticks are counted is ignored.
- R8: After the block's own frame, carrier seen at counts 40 to 59 restarts the first part from zero. The blinding window does not come back, so carrier early in the restarted gap resets it again.
- R9: With `post_tx_plain_gap` high, carrier never resets the gap that follows the block's own frame. The gap after a received frame still follows R3 and R4.
- R10: `tx_permit` falls in the same cycle that `tx_busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| carrier_sense | input | 1 | Carrier present on the medium |
| tx_busy | input | 1 | This station is sending a frame |
| tx_request | input | 1 | A frame is waiting to be sent |
| post_tx_plain_gap | input | 1 | 1: the gap after own frames counts straight through without the two-part rule |
| tx_permit | output | 1 | Transmission may start |

## Verification
Each bit tick is counted at the clock edge where it is high, and the phase register moves to ready at the same edge as the 96th tick. The permit therefore shows one cycle after that tick. A carrier pulse takes two edges to act: one edge moves the timer into the carrier hold, and the next edge returns it to counting at zero. `tx_permit` also depends directly on `tx_request` and `tx_busy`, so a change on either input shows in the same cycle. The bench drives inputs on the falling edge and samples shortly after it. For every starting count from 0 to 95 it predicts, from the 40/60/96 bounds, whether a carrier pulse resets the gap, and it checks that the permit is low one tick before the predicted end and high at the end.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

    typedef enum logic [1:0] {
        PH_TX    = 2'd0,
        PH_RX    = 2'd1,
        PH_GAP   = 2'd2,
        PH_READY = 2'd3
    } ifg_phase_e;

    typedef struct packed {
        ifg_phase_e phase;
        logic       post_tx;
    } ifg_state_t;

endpackage

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
    parameter int GAP_BITS = 96,
    parameter int CNT_W    = $clog2(GAP_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_last_o
);

    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(GAP_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_BITS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CNT_TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign at_last_o = (cnt_q == CNT_LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP); // R2

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/ifg_window_decode.sv
module ifg_window_decode #(
    parameter int PART1_BITS = 60,
    parameter int BLIND_BITS = 40,
    parameter int CNT_W      = 7
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             post_tx_i,
    input  logic             plain_gap_i,
    output logic             carrier_resets_o
);

    localparam logic [CNT_W-1:0] PART1_END = CNT_W'(PART1_BITS);
    localparam logic [CNT_W-1:0] BLIND_END = CNT_W'(BLIND_BITS);

    logic in_part1;
    logic in_blind;
    logic plain_after_tx;

    always_comb begin
        in_part1         = (cnt_i < PART1_END);
        in_blind         = post_tx_i && (cnt_i < BLIND_END);
        plain_after_tx   = post_tx_i && plain_gap_i;
        carrier_resets_o = in_part1 && !in_blind && !plain_after_tx;
    end

endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer #(
    parameter int GAP_BITS   = 96,
    parameter int PART1_BITS = 60,
    parameter int BLIND_BITS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic carrier_sense,
    input  logic tx_busy,
    input  logic tx_request,
    input  logic post_tx_plain_gap,
    output logic tx_permit
);

    import ifg_pkg::*;

    localparam int CNT_W = $clog2(GAP_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(GAP_BITS);
    localparam logic [CNT_W-1:0] PART1_END = CNT_W'(PART1_BITS);
    localparam logic [CNT_W-1:0] BLIND_END = CNT_W'(BLIND_BITS);

    ifg_state_t       st_d, st_q;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;
    logic             cnt_at_last;
    logic             carrier_resets;

    ifg_gap_counter #(
        .GAP_BITS (GAP_BITS),
        .CNT_W    (CNT_W)
    ) counter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .cnt_o     (cnt),
        .at_last_o (cnt_at_last)
    );

    ifg_window_decode #(
        .PART1_BITS (PART1_BITS),
        .BLIND_BITS (BLIND_BITS),
        .CNT_W      (CNT_W)
    ) decode_i (
        .cnt_i            (cnt),
        .post_tx_i        (st_q.post_tx),
        .plain_gap_i      (post_tx_plain_gap),
        .carrier_resets_o (carrier_resets)
    );

    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (tx_busy) begin
            st_d.phase   = PH_TX;
            st_d.post_tx = 1'b1;
            cnt_clr      = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_TX: begin
                    cnt_clr = 1'b1;
                    if (!carrier_sense) begin
                        st_d.phase = PH_GAP;
                    end
                end
                PH_RX: begin
                    cnt_clr = 1'b1;
                    if (!carrier_sense) begin
                        st_d.phase = PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (carrier_sense && carrier_resets) begin
                        st_d.phase   = PH_RX;
                        st_d.post_tx = 1'b0;
                        cnt_clr      = 1'b1;
                    end else if (bit_tick) begin
                        cnt_inc = 1'b1;
                        if (cnt_at_last) begin
                            st_d.phase = PH_READY;
                        end
                    end
                end
                PH_READY: begin
                    if (carrier_sense && !tx_request) begin
                        st_d.phase   = PH_RX;
                        st_d.post_tx = 1'b0;
                        cnt_clr      = 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_RX;
                    cnt_clr    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= PH_GAP;
            st_q.post_tx <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_permit = (st_q.phase == PH_READY) && tx_request && !tx_busy;

    AST_PERMIT_FULL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit |-> (cnt == CNT_TOP)); // R2

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_GAP && bit_tick && !carrier_sense && !tx_busy)
        |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_PART2_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_GAP && cnt >= PART1_END && !tx_busy)
        |=> (cnt >= PART1_END)); // R4

    AST_BLIND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_GAP && st_q.post_tx && cnt < BLIND_END && !tx_busy)
        |=> (cnt >= $past(cnt))); // R7

    AST_TX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> (st_q.phase == PH_TX && cnt == '0)); // R6

    AST_NO_PERMIT_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_permit); // R10

endmodule

// File: tb/ifg_defer_timer_tb.sv
module ifg_defer_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic carrier_sense = 1'b0;
    logic tx_busy = 1'b0;
    logic tx_request = 1'b0;
    logic post_tx_plain_gap = 1'b0;
    logic tx_permit;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ifg_defer_timer dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .bit_tick          (bit_tick),
        .carrier_sense     (carrier_sense),
        .tx_busy           (tx_busy),
        .tx_request        (tx_request),
        .post_tx_plain_gap (post_tx_plain_gap),
        .tx_permit         (tx_permit)
    );

    task automatic chk(input logic exp, input string tag, input int k);
        #1;
        total++;
        if (tx_permit !== exp) begin
            fails++;
            $display("FAIL %s (k=%0d): tx_permit=%0b expected %0b", tag, k, tx_permit, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            bit_tick = 1'b1;
            repeat (n) @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic pulse();
        carrier_sense = 1'b1;
        idle(1);
        carrier_sense = 1'b0;
        idle(1);
    endtask

    task automatic rx_frame();
        tx_request = 1'b0;
        carrier_sense = 1'b1;
        idle(2);
        carrier_sense = 1'b0;
        tx_request = 1'b1;
        idle(1);
    endtask

    task automatic tx_frame();
        tx_busy = 1'b1;
        idle(2);
        tx_busy = 1'b0;
        idle(1);
    endtask

    task automatic sweep(input bit after_tx, input bit plain);
        post_tx_plain_gap = plain;
        for (int k = 0; k < 96; k++) begin
            bit reset_exp;
            string tag;
            if (after_tx) begin
                tx_frame();
                reset_exp = !plain && (k >= 40) && (k < 60);
                if (plain)       tag = "R9";
                else if (k < 40) tag = "R7";
                else if (k < 60) tag = "R8";
                else             tag = "R4";
            end else begin
                rx_frame();
                reset_exp = (k < 60);
                if (plain)       tag = "R9";
                else if (k < 60) tag = "R3";
                else             tag = "R4";
            end
            ticks(k);
            pulse();
            if (reset_exp) begin
                ticks(95);
            end else begin
                ticks(95 - k);
            end
            chk(1'b0, tag, k);
            ticks(1);
            chk(1'b1, tag, k);
        end
        post_tx_plain_gap = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: run still busy, expected to be done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        tx_request = 1'b1;
        chk(1'b0, "R1", 0);
        // R1: gap from reset needs a full 96 ticks
        ticks(95);
        chk(1'b0, "R1", 95);
        ticks(1);
        chk(1'b1, "R1", 96);

        // R2: basic receive gap
        rx_frame();
        ticks(95);
        chk(1'b0, "R2", 95);
        ticks(1);
        chk(1'b1, "R2", 96);

        // R10: permit falls in the same cycle tx_busy rises
        tx_busy = 1'b1;
        chk(1'b0, "R10", 0);
        idle(1);

        // R6: no counting while busy, nor while carrier is up after the frame
        ticks(100);
        chk(1'b0, "R6", 100);
        carrier_sense = 1'b1;
        tx_busy = 1'b0;
        idle(1);
        ticks(100);
        chk(1'b0, "R6", 200);
        carrier_sense = 1'b0;
        idle(1);
        ticks(95);
        chk(1'b0, "R6", 95);
        ticks(1);
        chk(1'b1, "R6", 96);

        // R5: permit follows the request
        tx_request = 1'b0;
        chk(1'b0, "R5", 0);
        idle(1);
        tx_request = 1'b1;
        chk(1'b1, "R5", 1);

        // R4: permit at the end of the gap with carrier present
        rx_frame();
        ticks(70);
        carrier_sense = 1'b1;
        ticks(25);
        chk(1'b0, "R4", 95);
        ticks(1);
        chk(1'b1, "R4", 96);

        // R5: with no request, a ready timer defers to carrier
        tx_request = 1'b0;
        idle(1);
        tx_request = 1'b1;
        chk(1'b0, "R5", 2);
        carrier_sense = 1'b0;
        idle(1);
        ticks(95);
        chk(1'b0, "R5", 95);
        ticks(1);
        chk(1'b1, "R5", 96);

        // R8: restart after 40..59 does not bring blinding back
        tx_frame();
        ticks(45);
        pulse();
        ticks(10);
        pulse();
        ticks(95);
        chk(1'b0, "R8", 95);
        ticks(1);
        chk(1'b1, "R8", 96);

        sweep(1'b0, 1'b0);
        sweep(1'b1, 1'b0);
        sweep(1'b1, 1'b1);
        sweep(1'b0, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule